// File: doc/BRIEF.md
# I2C Wake-Pulse Sequencer

This block is the front end of an I2C master. Its job is to bring a sleeping secure element out of its low-power state before normal traffic starts. The device wakes when SDA stays low longer than a threshold. The block produces that low level with ordinary bus signalling: a START followed by eight zero bits, an all-zero address plus the write bit. The device cannot answer this frame, and the block expects no answer.

After the dummy frame the block leaves both lines released, with no STOP and no repeated START. It waits out the device's boot time and then sends a fresh START carrying the real 7-bit address. The acknowledge on the ninth clock decides the result. Either way the block closes the bus with a STOP. It raises a one-cycle completion pulse with a ready or fail flag. Data transfer after the address phase is left to the logic that follows.

The bit timing comes from parameters counted in system clocks, and so do the wake threshold and the boot wait. When the normal SCL timing is too fast to hold SDA low long enough, the block stretches the quarter-period of the dummy frame only. Both lines are open-drain: the block only pulls them low or lets go, and it reads back the synchronised line levels.

Top module: `i2c_wake_seq`

## Requirements
- R1: After reset both pull-low outputs are inactive, and `wake_done`, `dev_ready` and `dev_fail` are 0.
- R2: A `wake_req` seen while idle starts a START (SDA falls while SCL is released). Eight bits follow, all zero, sent MSB first. A bit is valid while SCL is released.
- R3: From the START's SDA fall until SDA is released at the ninth clock, SDA stays low for exactly 33*QD cycles, and this is always more than `WAKE_LOW_CYC`. QD = max(`QUARTER_CYC`, `WAKE_LOW_CYC`/33+1) is the dummy quarter-period.
- R4: After the dummy frame the block issues no STOP and no repeated START. The SDA fall of the next START comes exactly 4*QD + `BOOT_CYC` + `QUARTER_CYC` cycles after SDA was released at the dummy ninth clock.
- R5: The second frame carries the byte {`dev_addr`, 0}, MSB first, with `dev_addr` captured when the request was accepted. SDA is released on the ninth clock.
- R6: SDA low at the ninth clock of the second frame (ACK) gives `dev_ready`=1 and `dev_fail`=0. SDA high (NACK) gives `dev_fail`=1 and `dev_ready`=0. Both flags hold until the next accepted request, which clears them.
- R7: Exactly one STOP (SDA rises while SCL is released) ends the sequence. `wake_done` is high for exactly one cycle, in the cycle the flags become valid, and both lines are released at that point.
- R8: A `wake_req` that arrives while a sequence is running is ignored: no second sequence follows, and the address change has no effect.
- R9: A START is not begun while SCL or SDA reads low. The block waits until both read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req | input | 1 | Start a wake sequence (sampled while idle) |
| dev_addr | input | ADDR_W | 7-bit target address used in the second frame |
| wake_done | output | 1 | One-cycle completion pulse |
| dev_ready | output | 1 | Target acknowledged its address |
| dev_fail | output | 1 | Target did not acknowledge its address |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The bench builds the block with `QUARTER_CYC`=2, `WAKE_LOW_CYC`=100, `BOOT_CYC`=150 and two synchroniser stages. With these values the dummy quarter stretches to 4 cycles, so the stretched path and the normal path are both used in one run. A whole sequence also fits in a few hundred cycles. That makes it possible to sweep all 128 target addresses against a bus model that acknowledges only one address, and only after it has seen a long enough low and waited out its boot time. Extra runs hold SCL low before a request and fire a request in mid-sequence.

// File: rtl/iwk_pkg.sv
package iwk_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_STA_A,
      S_STA_B,
      S_BIT,
      S_BOOT,
      S_STO_A,
      S_STO_B,
      S_STO_C
   } iwk_state_e;

   // SDA-low span of the dummy frame in quarter periods: START hold + 8 bits.
   localparam int unsigned LOW_QUARTERS = 33;

   function automatic int unsigned dummy_quarter(input int unsigned qn,
                                                 input int unsigned wake_low);
      int unsigned need;
      need = wake_low / LOW_QUARTERS + 1;
      return (need > qn) ? need : qn;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/iwk_sync.sv
module iwk_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '1;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/iwk_timer.sv
module iwk_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         hold,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load)                    cnt_q <= load_val;
      else if (!hold && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/iwk_seq.sv
module iwk_seq
   import iwk_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned QN     = 2,
   parameter int unsigned QD     = 4,
   parameter int unsigned BOOT   = 150,
   parameter int unsigned TW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              t_zero,
   output logic              t_load,
   output logic [TW-1:0]     t_len,
   output logic              t_hold,
   output logic              scl_lo,
   output logic              sda_lo,
   output logic              done,
   output logic              ready,
   output logic              fail
);
   localparam int unsigned FRAME_W = ADDR_W + 1;
   localparam int unsigned BW      = $clog2(FRAME_W + 1);
   localparam logic [BW-1:0] ACK_IDX = BW'(FRAME_W);
   localparam logic [TW-1:0] LEN_N   = TW'(QN - 1);
   localparam logic [TW-1:0] LEN_D   = TW'(QD - 1);
   localparam logic [TW-1:0] LEN_B   = TW'(BOOT - 1);

   iwk_state_e          st_q, st_d;
   logic [1:0]          q_q, q_d;
   logic [BW-1:0]       bi_q, bi_d;
   logic                real_q, real_d;
   logic [FRAME_W-1:0]  sh_q, sh_d;
   logic [ADDR_W-1:0]   addr_q, addr_d;
   logic                ack_q, ack_d;
   logic                done_d, rdy_d, fail_d;
   logic                adv;
   logic [TW-1:0]       ql;

   assign ql     = real_q ? LEN_N : LEN_D;
   assign t_hold = (st_q == S_STA_A) && !(scl_s && sda_s);
   assign adv    = (st_q != S_IDLE) && t_zero && !t_hold;

   always_comb begin
      st_d   = st_q;
      q_d    = q_q;
      bi_d   = bi_q;
      real_d = real_q;
      sh_d   = sh_q;
      addr_d = addr_q;
      ack_d  = ack_q;
      done_d = 1'b0;
      rdy_d  = ready;
      fail_d = fail;
      t_load = 1'b0;
      t_len  = ql;
      case (st_q)
         S_IDLE: begin
            if (req) begin
               st_d   = S_STA_A;
               real_d = 1'b0;
               sh_d   = '0;
               addr_d = addr;
               rdy_d  = 1'b0;
               fail_d = 1'b0;
               q_d    = 2'd0;
               bi_d   = '0;
               t_load = 1'b1;
               t_len  = LEN_D;
            end
         end
         S_STA_A: begin
            if (adv) begin
               st_d   = S_STA_B;
               t_load = 1'b1;
            end
         end
         S_STA_B: begin
            if (adv) begin
               st_d   = S_BIT;
               q_d    = 2'd0;
               bi_d   = '0;
               t_load = 1'b1;
            end
         end
         S_BIT: begin
            if (adv) begin
               t_load = 1'b1;
               if (q_q == 2'd2 && bi_q == ACK_IDX) ack_d = !sda_s;
               if (q_q != 2'd3) begin
                  q_d = q_q + 2'd1;
               end else if (bi_q != ACK_IDX) begin
                  q_d  = 2'd0;
                  bi_d = bi_q + 1'b1;
                  sh_d = {sh_q[FRAME_W-2:0], 1'b0};
               end else if (!real_q) begin
                  st_d   = S_BOOT;
                  real_d = 1'b1;
                  t_len  = LEN_B;
               end else begin
                  st_d = S_STO_A;
               end
            end
         end
         S_BOOT: begin
            if (adv) begin
               st_d   = S_STA_A;
               sh_d   = {addr_q, 1'b0};
               q_d    = 2'd0;
               bi_d   = '0;
               t_load = 1'b1;
               t_len  = LEN_N;
            end
         end
         S_STO_A: begin
            if (adv) begin
               st_d   = S_STO_B;
               t_load = 1'b1;
            end
         end
         S_STO_B: begin
            if (adv) begin
               st_d   = S_STO_C;
               t_load = 1'b1;
            end
         end
         S_STO_C: begin
            if (adv) begin
               st_d   = S_IDLE;
               done_d = 1'b1;
               rdy_d  = ack_q;
               fail_d = !ack_q;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         q_q    <= 2'd0;
         bi_q   <= '0;
         real_q <= 1'b0;
         sh_q   <= '0;
         addr_q <= '0;
         ack_q  <= 1'b0;
         done   <= 1'b0;
         ready  <= 1'b0;
         fail   <= 1'b0;
      end else begin
         st_q   <= st_d;
         q_q    <= q_d;
         bi_q   <= bi_d;
         real_q <= real_d;
         sh_q   <= sh_d;
         addr_q <= addr_d;
         ack_q  <= ack_d;
         done   <= done_d;
         ready  <= rdy_d;
         fail   <= fail_d;
      end
   end

   // Line controls decoded straight from state registers.
   assign scl_lo = (st_q == S_BIT && !q_q[1]) || st_q == S_STO_A || st_q == S_STO_B;
   assign sda_lo = (st_q == S_STA_B)
                || (st_q == S_BIT && bi_q != ACK_IDX && !sh_q[FRAME_W-1])
                || (st_q == S_STO_B) || (st_q == S_STO_C);
endmodule

// File: rtl/i2c_wake_seq.sv
module i2c_wake_seq
   import iwk_pkg::*;
#(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned QUARTER_CYC  = 250,
   parameter int unsigned WAKE_LOW_CYC = 13000,
   parameter int unsigned BOOT_CYC     = 310000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_req,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              wake_done,
   output logic              dev_ready,
   output logic              dev_fail,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low
);
   localparam int unsigned QD = dummy_quarter(QUARTER_CYC, WAKE_LOW_CYC);
   localparam int unsigned TW = $clog2(max2(BOOT_CYC, QD) + 1);

   generate
      if (ADDR_W != 7)      begin : g_bad_addr  $error("ADDR_W must be 7");          end
      if (QUARTER_CYC < 2)  begin : g_bad_q     $error("QUARTER_CYC must be >= 2");  end
      if (BOOT_CYC < 1)     begin : g_bad_boot  $error("BOOT_CYC must be >= 1");     end
      if (SYNC_STAGES > 3)  begin : g_bad_sync  $error("SYNC_STAGES must be <= 3");  end
   endgenerate

   logic [1:0]    lines_s;
   logic          t_load, t_hold, t_zero;
   logic [TW-1:0] t_len;

   iwk_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (lines_s)
   );

   iwk_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_len),
      .hold     (t_hold),
      .zero     (t_zero)
   );

   iwk_seq #(
      .ADDR_W (ADDR_W),
      .QN     (QUARTER_CYC),
      .QD     (QD),
      .BOOT   (BOOT_CYC),
      .TW     (TW)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (wake_req),
      .addr   (dev_addr),
      .scl_s  (lines_s[1]),
      .sda_s  (lines_s[0]),
      .t_zero (t_zero),
      .t_load (t_load),
      .t_len  (t_len),
      .t_hold (t_hold),
      .scl_lo (scl_drive_low),
      .sda_lo (sda_drive_low),
      .done   (wake_done),
      .ready  (dev_ready),
      .fail   (dev_fail)
   );
endmodule

// File: rtl/iwk_chk.sv
module iwk_chk #(
   parameter int unsigned WAKE_LOW_CYC = 100,
   parameter int unsigned BOOT_CYC     = 150
) (
   input logic clk,
   input logic rst_n,
   input logic wake_done,
   input logic dev_ready,
   input logic dev_fail,
   input logic scl_drive_low,
   input logic sda_drive_low
);
   logic [31:0] rel_cnt, low_cnt;
   logic [1:0]  starts_sd;
   logic        sda_pv, wake_seen;
   logic        start_ev, sda_rel_ev;

   assign start_ev   = sda_drive_low && !sda_pv && !scl_drive_low;
   assign sda_rel_ev = !sda_drive_low && sda_pv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_cnt   <= '0;
         low_cnt   <= '0;
         starts_sd <= '0;
         sda_pv    <= 1'b0;
         wake_seen <= 1'b0;
      end else begin
         sda_pv  <= sda_drive_low;
         rel_cnt <= (!sda_drive_low && !scl_drive_low) ? rel_cnt + 1 : '0;
         low_cnt <= sda_drive_low ? low_cnt + 1 : '0;
         if (wake_done) begin
            starts_sd <= '0;
            wake_seen <= 1'b0;
         end else begin
            if (start_ev && starts_sd != 2'd3) starts_sd <= starts_sd + 2'd1;
            if (sda_rel_ev && starts_sd == 2'd1) wake_seen <= 1'b1;
         end
      end
   end

   // R3
   wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_rel_ev && starts_sd == 2'd1 && !wake_seen) |-> (low_cnt > 32'(WAKE_LOW_CYC)));
   // R4
   boot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev && starts_sd == 2'd1) |-> (rel_cnt >= 32'(BOOT_CYC)));
   // R6
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_ready && dev_fail));
   // R6
   done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |-> (dev_ready != dev_fail));
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |=> !wake_done);
   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |-> (!scl_drive_low && !sda_drive_low));
endmodule

bind i2c_wake_seq iwk_chk #(
   .WAKE_LOW_CYC (WAKE_LOW_CYC),
   .BOOT_CYC     (BOOT_CYC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wake_done     (wake_done),
   .dev_ready     (dev_ready),
   .dev_fail      (dev_fail),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_wake_seq_test.sv
`timescale 1ns/1ps
module i2c_wake_seq_test;
   localparam int QN   = 2;
   localparam int WAKE = 100;
   localparam int BOOT = 150;
   localparam int QD   = ((WAKE / 33 + 1) > QN) ? (WAKE / 33 + 1) : QN;
   localparam logic [6:0] DEV = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake_req = 1'b0;
   logic [6:0] dev_addr = '0;
   logic wake_done, dev_ready, dev_fail, scl_drive_low, sda_drive_low;
   logic ack_drv = 1'b0;
   logic ext_scl_low = 1'b0;
   logic clr_req = 1'b0;
   wire  scl_line = !(scl_drive_low || ext_scl_low);
   wire  sda_line = !(sda_drive_low || ack_drv);

   int checks = 0, fails = 0;
   int cyc = 0;

   always #2.5 clk = !clk;

   i2c_wake_seq #(
      .ADDR_W(7), .QUARTER_CYC(QN), .WAKE_LOW_CYC(WAKE), .BOOT_CYC(BOOT), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .dev_addr(dev_addr),
      .wake_done(wake_done), .dev_ready(dev_ready), .dev_fail(dev_fail),
      .scl_in(scl_line), .sda_in(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Bus and target model
   int n_starts, n_stops, early_stops, bitn, low_run, low_meas, gap_meas, rise_cyc, ready_at;
   logic [7:0] shb, byte0, byte1;
   logic woke, low_got, sda_pv, scl_pv;

   always @(negedge clk) begin
      logic s, c;
      s = sda_line;
      c = scl_line;
      if (!rst_n || clr_req) begin
         n_starts = 0; n_stops = 0; early_stops = 0; bitn = 9; low_run = 0;
         low_meas = -1; gap_meas = -1; rise_cyc = 0; ready_at = 1 << 30;
         shb = '0; byte0 = 8'hFF; byte1 = 8'hFF; woke = 0; low_got = 0;
         ack_drv = 0;
      end else begin
         if (sda_pv && !s && scl_pv && c) begin
            if (n_starts == 1) gap_meas = cyc - rise_cyc;
            n_starts++;
            bitn = 0;
            shb = '0;
         end
         if (!sda_pv && s && scl_pv && c) begin
            n_stops++;
            if (n_starts < 2) early_stops++;
         end
         if (!scl_pv && c && bitn < 9) begin
            if (bitn < 8) shb = {shb[6:0], s};
            bitn++;
            if (bitn == 8) begin
               if (n_starts == 1) byte0 = shb;
               else if (n_starts == 2) byte1 = shb;
            end
         end
         if (scl_pv && !c) begin
            if (ack_drv) ack_drv = 0;
            else if (bitn == 8 && woke && cyc >= ready_at && shb == {DEV, 1'b0}) ack_drv = 1;
         end
         if (!s) begin
            low_run++;
            if (low_run > WAKE) woke = 1;
         end
         if (!sda_pv && s) begin
            if (n_starts == 1 && !low_got) begin
               low_meas = low_run;
               low_got = 1;
               rise_cyc = cyc;
               if (woke) ready_at = cyc + BOOT;
            end
            low_run = 0;
         end
      end
      sda_pv = s;
      scl_pv = c;
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [6:0] a);
      @(posedge clk); #1;
      dev_addr = a; wake_req = 1'b1; clr_req = 1'b1;
      @(posedge clk); #1;
      wake_req = 1'b0; clr_req = 1'b0;
   endtask

   logic got_ready, got_fail;
   task automatic wait_done();
      int t;
      t = 0;
      while (!wake_done && t < 5000) begin @(negedge clk); t++; end
      check(wake_done == 1'b1, "R7 done seen", int'(wake_done), 1);
      got_ready = dev_ready;
      got_fail  = dev_fail;
      check(!scl_drive_low && !sda_drive_low, "R7 lines released at done",
            int'({scl_drive_low, sda_drive_low}), 0);
      @(negedge clk);
      check(!wake_done, "R7 done one cycle", int'(wake_done), 0);
   endtask

   always @(posedge clk) begin
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1
      check(!scl_drive_low && !sda_drive_low && !wake_done && !dev_ready && !dev_fail,
            "R1 reset state", int'({scl_drive_low, sda_drive_low, wake_done, dev_ready, dev_fail}), 0);

      for (int a = 0; a < 128; a++) begin
         logic exp_ack;
         exp_ack = (7'(a) == DEV);
         launch(7'(a));
         @(negedge clk);
         check(!dev_ready && !dev_fail, "R6 flags cleared on accept",
               int'({dev_ready, dev_fail}), 0);
         wait_done();
         check(byte0 == 8'h00, "R2 dummy byte zero", int'(byte0), 0);
         check(low_meas == 33 * QD && low_meas > WAKE, "R3 wake low length", low_meas, 33 * QD);
         check(gap_meas == 4 * QD + BOOT + QN, "R4 idle gap", gap_meas, 4 * QD + BOOT + QN);
         check(early_stops == 0 && n_starts == 2, "R4 no stop or restart between frames",
               early_stops * 10 + n_starts, 2);
         check(byte1 == {7'(a), 1'b0}, "R5 address byte", int'(byte1), int'({7'(a), 1'b0}));
         check(got_ready == exp_ack && got_fail == !exp_ack, "R6 status",
               int'({got_ready, got_fail}), int'({exp_ack, !exp_ack}));
         check(n_stops == 1, "R7 single stop", n_stops, 1);
      end

      // R8: request during a running sequence is ignored
      launch(DEV);
      repeat (60) @(posedge clk);
      #1 dev_addr = 7'h11; wake_req = 1'b1;
      @(posedge clk); #1 wake_req = 1'b0;
      wait_done();
      check(got_ready && byte1 == {DEV, 1'b0}, "R8 busy request ignored",
            int'(byte1), int'({DEV, 1'b0}));
      repeat (100) @(negedge clk);
      check(n_starts == 2 && !sda_drive_low && !scl_drive_low, "R8 no second sequence", n_starts, 2);

      // R9: START waits for a free bus
      @(posedge clk); #1 ext_scl_low = 1'b1;
      repeat (5) @(posedge clk);
      launch(DEV);
      repeat (50) @(negedge clk);
      check(!sda_drive_low && !scl_drive_low && n_starts == 0, "R9 start held off",
            int'(sda_drive_low), 0);
      @(posedge clk); #1 ext_scl_low = 1'b0;
      wait_done();
      check(got_ready && !got_fail && byte0 == 8'h00, "R9 sequence after release",
            int'(got_ready), 1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule